// File: doc/BRIEF.md
# Byte Register Access Decoder with Address-Encoded Operations

This block is the host-facing front end of a network adapter's attachment control area. Each host access is one byte wide and carries a request strobe. The low nine bits of the address hold everything the block needs. They give a register index, an operation code and an area select. The operation can be a plain store, an atomic AND, an atomic OR or a read. Because the operation sits in the address rather than in a strobe or data field, a single host store can clear or set selected bits of a control register. No other host access can slip in between the read and the write-back.

The block holds a bank of up to 32 byte registers. A parameter mask marks which indices are implemented. Two identification areas are read-only and return fixed bytes. Area A returns a parameterised encoded adapter address. Area B returns test patterns computed from the index. Accesses to missing registers, to the reserved area and to the read-only areas raise a one-cycle access error and change nothing. The host window normally places this area at byte offset 0x1E00. Only the nine offset bits inside the area reach the block.

Top module: `mmio_aca_decoder`

## Requirements
- R1: Address bits [4:0] select the register index. Every operation acts on exactly the register that the index names.
- R2: With operation code 00 (bits [6:5]) in area 00 (bits [8:7]), an implemented register takes the data byte.
- R3: With operation code 01 in area 00, an implemented register becomes its old value AND the data byte. The access produces no read response.
- R4: With operation code 10 in area 00, an implemented register becomes its old value OR the data byte. The access produces no read response.
- R5: Operation code 11 is a read. The cycle after the strobe, `rvalid_o` is high and `rdata_o` carries the byte. When `rvalid_o` is low, `rdata_o` is zero.
- R6: Code 00, 01 or 10 sent to an index whose bit in `IMPL_MASK` is 0 changes no register. It raises `acc_err_o` the cycle after the strobe.
- R7: Any access to area 01 (reserved) raises `acc_err_o` the next cycle and changes no register. A read there returns zero.
- R8: A read in area 10 returns byte (index mod `ID_A_BYTES`) of `ID_A`, with byte 0 as the least significant, and raises no error.
- R9: A read in area 11 returns ((index << 3) XOR `B_SEED`), truncated to 8 bits, and raises no error.
- R10: Code 00, 01 or 10 sent to area 10 or 11 raises `acc_err_o` and changes neither the register bank nor the returned patterns.
- R11: After reset every register holds its byte of `RST_VALS`, and `rvalid_o`, `rdata_o` and `acc_err_o` are zero.
- R12: A read of an unimplemented index in area 00 returns zero and raises `acc_err_o`.
- R13: A cycle with the strobe low leaves `rvalid_o` and `acc_err_o` low the next cycle and changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access strobe, one cycle per access |
| addr_i | input | 9 | Offset inside the area: [4:0] index, [6:5] operation, [8:7] area |
| wdata_i | input | 8 | Data byte for store, AND and OR |
| rdata_o | output | 8 | Registered read data |
| rvalid_o | output | 1 | Read response valid |
| acc_err_o | output | 1 | Access error pulse |

## Verification
The bench sweeps every index in all four areas under all four operation codes. It follows each modifying access with a read, so that store, AND and OR become visible at the ports.

The data bytes change with the index. Because of this, a decoder that swaps the AND and OR codes, or that sends an update to a neighbouring index, produces a mismatch. Every read and write sent to the reserved and identification areas is followed by a full re-read of the bank, which separates real read-only behaviour from silent corruption. Reset values include non-zero bytes so that a wrong reset constant shows up.

// File: rtl/mmio_aca_pkg.sv
package mmio_aca_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b00,
        OP_AND   = 2'b01,
        OP_OR    = 2'b10,
        OP_READ  = 2'b11
    } acc_op_e;

    typedef enum logic [1:0] {
        AR_CTRL = 2'b00,
        AR_RSVD = 2'b01,
        AR_ID_A = 2'b10,
        AR_ID_B = 2'b11
    } acc_area_e;

    typedef struct packed {
        acc_op_e   op;
        acc_area_e area;
        logic      idx_ok;
        logic      modify;
        logic      err;
    } acc_cmd_t;

endpackage

// File: rtl/mmio_addr_decode.sv
module mmio_addr_decode
    import mmio_aca_pkg::*;
#(
    parameter int unsigned IDX_W     = 5,
    parameter int unsigned NREG      = 2 ** IDX_W,
    parameter logic [NREG-1:0] IMPL_MASK = '1,
    localparam int unsigned ADDR_W   = IDX_W + 4
) (
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [IDX_W-1:0]  idx_o,
    output acc_cmd_t          cmd_o
);

    always_comb begin
        cmd_o        = '0;
        idx_o        = addr_i[IDX_W-1:0];
        cmd_o.op     = acc_op_e'(addr_i[IDX_W+1:IDX_W]);
        cmd_o.area   = acc_area_e'(addr_i[IDX_W+3:IDX_W+2]);
        cmd_o.idx_ok = IMPL_MASK[idx_o];
        unique case (cmd_o.area)
            AR_CTRL: cmd_o.err = !cmd_o.idx_ok;
            AR_RSVD: cmd_o.err = 1'b1;
            default: cmd_o.err = (cmd_o.op != OP_READ);
        endcase
        cmd_o.modify = req_i && (cmd_o.area == AR_CTRL) && cmd_o.idx_ok
                       && (cmd_o.op != OP_READ);
    end

endmodule

// File: rtl/mmio_reg_bank.sv
module mmio_reg_bank
    import mmio_aca_pkg::*;
#(
    parameter int unsigned IDX_W  = 5,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned NREG   = 2 ** IDX_W,
    parameter logic [NREG*DATA_W-1:0] RST_VALS = '0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              modify_i,
    input  acc_op_e           op_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rd_data_o
);

    logic [NREG-1:0][DATA_W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (modify_i) begin
            unique case (op_i)
                OP_WRITE: regs_d[idx_i] = wdata_i;
                OP_AND:   regs_d[idx_i] = regs_q[idx_i] & wdata_i;
                OP_OR:    regs_d[idx_i] = regs_q[idx_i] | wdata_i;
                default:  regs_d[idx_i] = regs_q[idx_i];
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= RST_VALS;
        else         regs_q <= regs_d;
    end

    assign rd_data_o = regs_q[idx_i];

    for (genvar g = 0; g < NREG; g++) begin : g_chk
        // R2
        wr_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (modify_i && op_i == OP_WRITE && idx_i == g)
            |=> regs_q[g] == $past(wdata_i));
        // R3
        and_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (modify_i && op_i == OP_AND && idx_i == g)
            |=> regs_q[g] == ($past(regs_q[g]) & $past(wdata_i)));
        // R4
        or_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (modify_i && op_i == OP_OR && idx_i == g)
            |=> regs_q[g] == ($past(regs_q[g]) | $past(wdata_i)));
        // R1
        idx_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (idx_i != g || !modify_i) |=> $stable(regs_q[g]));
    end

endmodule

// File: rtl/mmio_id_patterns.sv
module mmio_id_patterns #(
    parameter int unsigned IDX_W      = 5,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned ID_A_BYTES = 8,
    parameter logic [ID_A_BYTES*DATA_W-1:0] ID_A = '0,
    parameter logic [DATA_W-1:0] B_SEED = 8'hA5
) (
    input  logic              area_b_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [DATA_W-1:0] byte_o
);

    logic [DATA_W-1:0] a_byte, b_byte;
    int unsigned       a_sel;

    always_comb begin
        a_sel  = 32'(idx_i) % ID_A_BYTES;
        a_byte = ID_A[a_sel*DATA_W +: DATA_W];
        b_byte = (DATA_W'(idx_i) << 3) ^ B_SEED;
        byte_o = area_b_i ? b_byte : a_byte;
    end

endmodule

// File: rtl/mmio_aca_decoder.sv
module mmio_aca_decoder
    import mmio_aca_pkg::*;
#(
    parameter int unsigned IDX_W      = 5,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned ID_A_BYTES = 8,
    parameter logic [2**IDX_W-1:0] IMPL_MASK = 32'h0300_FFFF,
    parameter logic [(2**IDX_W)*DATA_W-1:0] RST_VALS = '0,
    parameter logic [ID_A_BYTES*DATA_W-1:0] ID_A = 64'h0C1D_2E3F_4051_6273,
    parameter logic [DATA_W-1:0] B_SEED = 8'hA5,
    localparam int unsigned NREG   = 2 ** IDX_W,
    localparam int unsigned ADDR_W = IDX_W + 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic              acc_err_o
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
        logic              err;
    } resp_t;

    resp_t             resp_d, resp_q;
    acc_cmd_t          cmd;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] bank_byte, id_byte;

    mmio_addr_decode #(
        .IDX_W(IDX_W), .NREG(NREG), .IMPL_MASK(IMPL_MASK)
    ) u_dec (
        .req_i(req_i), .addr_i(addr_i), .idx_o(idx), .cmd_o(cmd)
    );

    mmio_reg_bank #(
        .IDX_W(IDX_W), .DATA_W(DATA_W), .NREG(NREG), .RST_VALS(RST_VALS)
    ) u_bank (
        .clk_i(clk_i), .rst_ni(rst_ni), .modify_i(cmd.modify), .op_i(cmd.op),
        .idx_i(idx), .wdata_i(wdata_i), .rd_data_o(bank_byte)
    );

    mmio_id_patterns #(
        .IDX_W(IDX_W), .DATA_W(DATA_W), .ID_A_BYTES(ID_A_BYTES),
        .ID_A(ID_A), .B_SEED(B_SEED)
    ) u_id (
        .area_b_i(cmd.area == AR_ID_B), .idx_i(idx), .byte_o(id_byte)
    );

    always_comb begin
        resp_d        = '0;
        resp_d.err    = req_i && cmd.err;
        resp_d.rvalid = req_i && (cmd.op == OP_READ);
        if (resp_d.rvalid) begin
            unique case (cmd.area)
                AR_CTRL: resp_d.rdata = cmd.idx_ok ? bank_byte : '0;
                AR_RSVD: resp_d.rdata = '0;
                default: resp_d.rdata = id_byte;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) resp_q <= '0;
        else         resp_q <= resp_d;
    end

    assign rdata_o   = resp_q.rdata;
    assign rvalid_o  = resp_q.rvalid;
    assign acc_err_o = resp_q.err;

    // R5
    read_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && addr_i[IDX_W+1:IDX_W] == 2'b11) |=> rvalid_o);
    // R13
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |=> (!rvalid_o && !acc_err_o));
    // R7
    rsvd_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && addr_i[ADDR_W-1:ADDR_W-2] == 2'b01) |=> acc_err_o);
    // R10
    id_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && addr_i[ADDR_W-1] && addr_i[IDX_W+1:IDX_W] != 2'b11) |=> acc_err_o);
    // R3
    no_rsp_on_modify_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && addr_i[IDX_W+1:IDX_W] != 2'b11) |=> !rvalid_o);

endmodule

// File: tb/mmio_aca_decoder_tb_top.sv
module mmio_aca_decoder_tb_top;

    localparam logic [31:0]  TB_MASK = 32'h0300_FFFF;
    localparam logic [255:0] TB_RST  = (256'h0C << 8) | (256'h40 << 64) | (256'h81 << 200);
    localparam logic [63:0]  TB_IDA  = 64'h0C1D_2E3F_4051_6273;
    localparam logic [7:0]   TB_SEED = 8'hA5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic [8:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rvalid, acc_err;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] model [32];

    always #5 clk = ~clk;

    mmio_aca_decoder #(
        .IMPL_MASK(TB_MASK), .RST_VALS(TB_RST), .ID_A(TB_IDA), .B_SEED(TB_SEED)
    ) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .acc_err_o(acc_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic [1:0] area, input logic [1:0] op, input int idx,
                       input logic [7:0] wd, input logic exp_v, input logic [7:0] exp_d,
                       input logic exp_e, input string tag);
        @(negedge clk);
        req = 1'b1; addr = {area, op, idx[4:0]}; wdata = wd;
        @(negedge clk);
        req = 1'b0;
        chk({tag, " rvalid"}, rvalid, exp_v);
        chk({tag, " rdata"}, rdata, exp_d);
        chk({tag, " acc_err"}, acc_err, exp_e);
    endtask

    function automatic logic [7:0] exp_rd(input int idx);
        return TB_MASK[idx] ? model[idx] : 8'h00;
    endfunction

    task automatic read_all(input string tag);
        for (int i = 0; i < 32; i++)
            acc(2'b00, 2'b11, i, 8'h00, 1'b1, exp_rd(i), !TB_MASK[i], tag);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = TB_RST[i*8 +: 8];
        repeat (3) @(negedge clk);
        // R11 reset state at the ports
        chk("R11 rvalid", rvalid, 0);
        chk("R11 rdata", rdata, 0);
        chk("R11 acc_err", acc_err, 0);
        rst_n = 1'b1;
        read_all("R11 R12 reset read");

        // R13 idle cycle
        @(negedge clk); @(negedge clk);
        chk("R13 rvalid", rvalid, 0);
        chk("R13 acc_err", acc_err, 0);

        // R2 R6 store sweep
        for (int i = 0; i < 32; i++) begin
            logic [7:0] d = 8'(i * 37 + 3);
            acc(2'b00, 2'b00, i, d, 1'b0, 8'h00, !TB_MASK[i], "R2 R6 store");
            if (TB_MASK[i]) model[i] = d;
        end
        read_all("R1 R2 R6 after store");

        // R3 AND sweep
        for (int i = 0; i < 32; i++) begin
            logic [7:0] d = 8'hF0 ^ 8'(i * 5);
            acc(2'b00, 2'b01, i, d, 1'b0, 8'h00, !TB_MASK[i], "R3 R6 and");
            if (TB_MASK[i]) model[i] = model[i] & d;
        end
        read_all("R1 R3 after and");

        // R4 OR sweep
        for (int i = 0; i < 32; i++) begin
            logic [7:0] d = 8'h0F ^ 8'(i * 9);
            acc(2'b00, 2'b10, i, d, 1'b0, 8'h00, !TB_MASK[i], "R4 R6 or");
            if (TB_MASK[i]) model[i] = model[i] | d;
        end
        read_all("R1 R4 after or");

        // R7 reserved area, all ops
        for (int i = 0; i < 32; i++)
            for (int op = 0; op < 4; op++)
                acc(2'b01, 2'(op), i, 8'h5A, op == 3, 8'h00, 1'b1, "R7 reserved");
        read_all("R7 bank unchanged");

        // R8 R9 identification reads
        for (int i = 0; i < 32; i++) begin
            acc(2'b10, 2'b11, i, 8'h00, 1'b1, TB_IDA[(i % 8)*8 +: 8], 1'b0, "R8 id A");
            acc(2'b11, 2'b11, i, 8'h00, 1'b1, 8'((i << 3) ^ TB_SEED), 1'b0, "R9 id B");
        end

        // R10 writes to read-only areas
        for (int i = 0; i < 32; i++)
            for (int op = 0; op < 3; op++) begin
                acc(2'b10, 2'(op), i, 8'hFF, 1'b0, 8'h00, 1'b1, "R10 id A modify");
                acc(2'b11, 2'(op), i, 8'h00, 1'b0, 8'h00, 1'b1, "R10 id B modify");
            end
        for (int i = 0; i < 32; i++) begin
            acc(2'b10, 2'b11, i, 8'h00, 1'b1, TB_IDA[(i % 8)*8 +: 8], 1'b0, "R10 id A reread");
            acc(2'b11, 2'b11, i, 8'h00, 1'b1, 8'((i << 3) ^ TB_SEED), 1'b0, "R10 id B reread");
        end
        read_all("R10 bank unchanged");

        // R13 idle does not disturb state
        repeat (4) @(negedge clk);
        chk("R13 idle rvalid", rvalid, 0);
        read_all("R13 bank after idle");

        finish_run();
    end

endmodule